// File: doc/BRIEF.md
# Prefix-Tree Group Index Lookup

This block assigns a group number to each incoming data word according to the top `IDX_W` bits of the word. Those bits are split into digits of `DIG_W` bits, and the digits are consumed from the most significant end, one per level of a tree with `2^DIG_W` branches per node. The tree lives in a single on-chip table. An internal entry stores the table address of its first child slot. Child `d` of a node sits at that address plus `d`, and the root's children occupy addresses `0 .. 2^DIG_W-1`.

A walk that reaches an entry tagged as empty builds the missing part of the path on the fly. Below the last level it takes a block of `2^DIG_W` fresh slots from a free pointer, marks them empty, links them from the entry and goes on walking. At the last level it writes a fresh group number into the entry and reports the group as newly created. Group numbers are handed out in creation order, starting from zero. When the table has no room left for a block of child slots, the result is the reserved all-ones tag together with an overflow flag.

Keys arrive through a valid/ready handshake, and one key is processed at a time. Results come out as a one-cycle pulse. After reset, and on every pulse of the init input, the whole table is rewritten to the empty tag and allocation starts again from the beginning.

Top module: `gidx_tree_lookup`

## Requirements
- R1: While reset is applied, `key_ready_o` and `res_valid_o` are low. After reset is released the table is cleared, so `key_ready_o` stays low for at least `DEPTH` cycles, and at most `DEPTH+3` cycles, before it first rises.
- R2: The first key whose top `IDX_W` bits form a prefix not seen since the last clear returns `res_new_o`=1, `res_ovf_o`=0 and a group number equal to the count of groups created before it since that clear (0, 1, 2, ...).
- R3: A key whose prefix is already known returns that prefix's group number with `res_new_o`=0. The low `DATA_W-IDX_W` key bits have no effect on the result.
- R4: `res_valid_o` is high for exactly one cycle. That cycle is the `2*L + 2^DIG_W*A + 1`-th cycle after the accepting edge, where `L` is the number of levels whose entry was read and `A` is the number of child blocks created by this key.
- R5: `key_ready_o` is low from the accepting edge through the result cycle, and high again in the cycle after it when no init is pending.
- R6: Digits are consumed most significant first. Any node already created for a shared leading digit string is reused. A new key that differs from a known key only in its last digit therefore creates no block and reads all `IDX_W/DIG_W` levels.
- R7: If a walk needs a new block and fewer than `2^DIG_W` slots remain, the result carries `res_ovf_o`=1, `res_new_o`=0 and the group number all ones (63 at the default width). Blocks created at earlier levels of the same walk stay in the table.
- R8: After an overflow, known prefixes still return their group numbers, and a new prefix whose path of nodes already exists still creates a group.
- R9: An init pulse seen while idle wins over a key offered in the same cycle and accepts no key. `key_ready_o` is then low for exactly `DEPTH` cycles, all groups are forgotten, and group numbering restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_i | input | 1 | Clears the table and restarts allocation when sampled while idle |
| key_valid_i | input | 1 | A key is offered |
| key_ready_o | output | 1 | A key can be accepted this cycle |
| key_i | input | DATA_W | Key word; only the top IDX_W bits are used |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_gid_o | output | GID_W | Group number, or all ones on overflow |
| res_new_o | output | 1 | The group was created by this key |
| res_ovf_o | output | 1 | The table had no room for a needed node |

## Verification
The key sequence is chosen so that the latency of each result tells the paths apart. A prefix that creates two nodes takes 15 cycles, one that creates a single node takes 11, one that only fills a last-level slot takes 7, and a repeated prefix with different low bits also takes 7. The table is then filled on purpose, so that overflow is hit first at the top level and then at the middle level. These two cases give results after 3 and 5 cycles, which shows that the walk stops at the failing level. Retrievals and a leaf insert after the overflow show that the table is left intact. An init pulse offered together with a key, followed by the same prefixes again, shows that clearing forgets all groups and that numbering restarts at 0.

// File: rtl/gidx_pkg.sv
package gidx_pkg;

  // Entry kind in the two top bits of a table word; an empty word is all ones
  localparam logic [1:0] KIND_NODE  = 2'b01;
  localparam logic [1:0] KIND_GROUP = 2'b10;
  localparam logic [1:0] KIND_EMPTY = 2'b11;

  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_IDLE  = 3'd1,
    ST_READ  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_FILL  = 3'd4,
    ST_DONE  = 3'd5
  } walk_state_e;

endpackage

// File: rtl/gidx_table.sv
module gidx_table #(
  parameter int DEPTH = 32,
  parameter int ENT_W = 8
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [ENT_W-1:0]         wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [ENT_W-1:0]         rdata_o
);

  logic [ENT_W-1:0] mem_q [DEPTH];

  // Single write port, synchronous read: data for an address shows one cycle later
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/gidx_alloc.sv
module gidx_alloc #(
  parameter int DEPTH = 32,
  parameter int DIG_W = 2,
  parameter int GID_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     take_node_i,
  input  logic                     take_gid_i,
  output logic [$clog2(DEPTH)-1:0] base_o,
  output logic                     room_o,
  output logic [GID_W-1:0]         gid_o,
  output logic                     gid_full_o
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int FAN    = 1 << DIG_W;
  localparam int PTR_W  = ADDR_W + 2;

  logic [PTR_W-1:0] free_q, free_d;
  logic [GID_W-1:0] gcnt_q, gcnt_d;
  logic             free_en, gcnt_en;

  always_comb begin
    free_en = clear_i | take_node_i;
    free_d  = clear_i ? PTR_W'(FAN) : free_q + PTR_W'(FAN);
    gcnt_en = clear_i | take_gid_i;
    gcnt_d  = clear_i ? '0 : gcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= PTR_W'(FAN);
      gcnt_q <= '0;
    end else begin
      if (free_en) free_q <= free_d;
      if (gcnt_en) gcnt_q <= gcnt_d;
    end
  end

  assign base_o     = free_q[ADDR_W-1:0];
  assign room_o     = (free_q + PTR_W'(FAN)) <= PTR_W'(DEPTH);
  assign gid_o      = gcnt_q;
  assign gid_full_o = &gcnt_q;

  // R7: a block is only taken when it fits
  a_r7_node_fits: assert property (@(posedge clk) disable iff (!rst_ni)
    take_node_i |-> room_o);
  // R7: the free pointer never passes the end of the table
  a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    free_q <= PTR_W'(DEPTH));

endmodule

// File: rtl/gidx_walker.sv
module gidx_walker
  import gidx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int DIG_W  = 2,
  parameter int DEPTH  = 32,
  parameter int GID_W  = 6
) (
  input  logic                                        clk,
  input  logic                                        rst_ni,
  input  logic                                        init_i,
  input  logic                                        key_valid_i,
  output logic                                        key_ready_o,
  input  logic [DATA_W-1:0]                           key_i,
  output logic                                        res_valid_o,
  output logic [GID_W-1:0]                            res_gid_o,
  output logic                                        res_new_o,
  output logic                                        res_ovf_o,
  output logic                                        tbl_we_o,
  output logic [$clog2(DEPTH)-1:0]                    tbl_waddr_o,
  output logic [(($clog2(DEPTH) > GID_W) ? $clog2(DEPTH) : GID_W)+1:0] tbl_wdata_o,
  output logic [$clog2(DEPTH)-1:0]                    tbl_raddr_o,
  input  logic [(($clog2(DEPTH) > GID_W) ? $clog2(DEPTH) : GID_W)+1:0] tbl_rdata_i,
  output logic                                        al_clear_o,
  output logic                                        al_node_o,
  output logic                                        al_gid_o,
  input  logic [$clog2(DEPTH)-1:0]                    al_base_i,
  input  logic                                        al_room_i,
  input  logic [GID_W-1:0]                            al_gid_i,
  input  logic                                        al_gid_full_i
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PAY_W  = (ADDR_W > GID_W) ? ADDR_W : GID_W;
  localparam int ENT_W  = PAY_W + 2;
  localparam int FAN    = 1 << DIG_W;
  localparam int LEVELS = IDX_W / DIG_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0]  LAST_LVL = LVL_W'(LEVELS - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] FAN_END  = ADDR_W'(FAN - 1);

  walk_state_e       state_q, state_d;
  logic [IDX_W-1:0]  key_q, key_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [GID_W-1:0]  gid_q, gid_d;
  logic              new_q, new_d;
  logic              ovf_q, ovf_d;
  logic              key_en;

  logic [1:0]        rd_kind;
  logic [ADDR_W-1:0] rd_base;
  logic [GID_W-1:0]  rd_gid;
  logic [DIG_W-1:0]  next_dig;

  // Digit of the stored prefix for a given level, most significant first
  function automatic logic [DIG_W-1:0] digit_at(input logic [IDX_W-1:0] k,
                                                input logic [LVL_W-1:0] l);
    logic [IDX_W-1:0] sh;
    sh = k << (int'(l) * DIG_W);
    return sh[IDX_W-1 -: DIG_W];
  endfunction

  assign rd_kind  = tbl_rdata_i[ENT_W-1 -: 2];
  assign rd_base  = tbl_rdata_i[ADDR_W-1:0];
  assign rd_gid   = tbl_rdata_i[GID_W-1:0];
  assign next_dig = digit_at(key_q, lvl_q + 1'b1);

  always_comb begin
    state_d     = state_q;
    key_d       = key_i[DATA_W-1 -: IDX_W];
    key_en      = 1'b0;
    lvl_d       = lvl_q;
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    base_d      = base_q;
    gid_d       = gid_q;
    new_d       = new_q;
    ovf_d       = ovf_q;
    tbl_we_o    = 1'b0;
    tbl_waddr_o = addr_q;
    tbl_wdata_o = '1;
    al_clear_o  = 1'b0;
    al_node_o   = 1'b0;
    al_gid_o    = 1'b0;
    unique case (state_q)
      ST_CLEAR: begin
        tbl_we_o    = 1'b1;
        tbl_waddr_o = cnt_q;
        if (cnt_q == TOP_ADDR) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (init_i) begin
          al_clear_o = 1'b1;
          cnt_d      = '0;
          state_d    = ST_CLEAR;
        end else if (key_valid_i) begin
          key_en  = 1'b1;
          lvl_d   = '0;
          addr_d  = ADDR_W'(key_i[DATA_W-1 -: DIG_W]);
          state_d = ST_READ;
        end
      end
      ST_READ: state_d = ST_EVAL;
      ST_EVAL: begin
        if (rd_kind == KIND_NODE && lvl_q != LAST_LVL) begin
          addr_d  = rd_base + ADDR_W'(next_dig);
          lvl_d   = lvl_q + 1'b1;
          state_d = ST_READ;
        end else if (rd_kind == KIND_GROUP) begin
          gid_d   = rd_gid;
          new_d   = 1'b0;
          ovf_d   = 1'b0;
          state_d = ST_DONE;
        end else if (lvl_q == LAST_LVL) begin
          state_d = ST_DONE;
          if (al_gid_full_i) begin
            gid_d = '1;
            new_d = 1'b0;
            ovf_d = 1'b1;
          end else begin
            tbl_we_o    = 1'b1;
            tbl_wdata_o = {KIND_GROUP, PAY_W'(al_gid_i)};
            al_gid_o    = 1'b1;
            gid_d       = al_gid_i;
            new_d       = 1'b1;
            ovf_d       = 1'b0;
          end
        end else if (!al_room_i) begin
          gid_d   = '1;
          new_d   = 1'b0;
          ovf_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          tbl_we_o    = 1'b1;
          tbl_wdata_o = {KIND_NODE, PAY_W'(al_base_i)};
          al_node_o   = 1'b1;
          base_d      = al_base_i;
          cnt_d       = '0;
          state_d     = ST_FILL;
        end
      end
      ST_FILL: begin
        tbl_we_o    = 1'b1;
        tbl_waddr_o = base_q + cnt_q;
        if (cnt_q == FAN_END) begin
          cnt_d   = '0;
          addr_d  = base_q + ADDR_W'(next_dig);
          lvl_d   = lvl_q + 1'b1;
          state_d = ST_READ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLEAR;
      key_q   <= '0;
      lvl_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      gid_q   <= '0;
      new_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (key_en) key_q <= key_d;
      lvl_q   <= lvl_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      gid_q   <= gid_d;
      new_q   <= new_d;
      ovf_q   <= ovf_d;
    end
  end

  assign tbl_raddr_o = addr_q;
  assign key_ready_o = (state_q == ST_IDLE) && !init_i;
  assign res_valid_o = (state_q == ST_DONE);
  assign res_gid_o   = gid_q;
  assign res_new_o   = new_q;
  assign res_ovf_o   = ovf_q;

  // R5: an accepted key blocks the next one
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> !key_ready_o);
  // R4: the result strobe lasts one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  // R7: overflow carries the reserved tag and never a new group
  a_r7_ovf_tag: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid_o && res_ovf_o) |-> ((&res_gid_o) && !res_new_o));
  // R2: a created group never carries the reserved tag
  a_r2_new_not_tag: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid_o && res_new_o) |-> !(&res_gid_o));
  // R1: every table write stays inside the table
  a_r1_write_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    tbl_we_o |-> (int'(tbl_waddr_o) < DEPTH));

endmodule

// File: rtl/gidx_tree_lookup.sv
module gidx_tree_lookup #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int DIG_W  = 2,
  parameter int DEPTH  = 32,
  parameter int GID_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              key_valid_i,
  output logic              key_ready_o,
  input  logic [DATA_W-1:0] key_i,
  output logic              res_valid_o,
  output logic [GID_W-1:0]  res_gid_o,
  output logic              res_new_o,
  output logic              res_ovf_o
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PAY_W  = (ADDR_W > GID_W) ? ADDR_W : GID_W;
  localparam int ENT_W  = PAY_W + 2;

  logic              rst_meta_q, rst_sync_q;
  logic              tbl_we;
  logic [ADDR_W-1:0] tbl_waddr, tbl_raddr;
  logic [ENT_W-1:0]  tbl_wdata, tbl_rdata;
  logic              al_clear, al_node, al_gid, al_room, al_gid_full;
  logic [ADDR_W-1:0] al_base;
  logic [GID_W-1:0]  al_gid_val;

  // Reset asserts at once and is released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gidx_table #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_table (
    .clk     (clk),
    .we_i    (tbl_we),
    .waddr_i (tbl_waddr),
    .wdata_i (tbl_wdata),
    .raddr_i (tbl_raddr),
    .rdata_o (tbl_rdata)
  );

  gidx_alloc #(.DEPTH(DEPTH), .DIG_W(DIG_W), .GID_W(GID_W)) u_alloc (
    .clk         (clk),
    .rst_ni      (rst_sync_q),
    .clear_i     (al_clear),
    .take_node_i (al_node),
    .take_gid_i  (al_gid),
    .base_o      (al_base),
    .room_o      (al_room),
    .gid_o       (al_gid_val),
    .gid_full_o  (al_gid_full)
  );

  gidx_walker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .DIG_W  (DIG_W),
    .DEPTH  (DEPTH),
    .GID_W  (GID_W)
  ) u_walker (
    .clk           (clk),
    .rst_ni        (rst_sync_q),
    .init_i        (init_i),
    .key_valid_i   (key_valid_i),
    .key_ready_o   (key_ready_o),
    .key_i         (key_i),
    .res_valid_o   (res_valid_o),
    .res_gid_o     (res_gid_o),
    .res_new_o     (res_new_o),
    .res_ovf_o     (res_ovf_o),
    .tbl_we_o      (tbl_we),
    .tbl_waddr_o   (tbl_waddr),
    .tbl_wdata_o   (tbl_wdata),
    .tbl_raddr_o   (tbl_raddr),
    .tbl_rdata_i   (tbl_rdata),
    .al_clear_o    (al_clear),
    .al_node_o     (al_node),
    .al_gid_o      (al_gid),
    .al_base_i     (al_base),
    .al_room_i     (al_room),
    .al_gid_i      (al_gid_val),
    .al_gid_full_i (al_gid_full)
  );

endmodule

// File: tb/gidx_tree_lookup_tb_top.sv
module gidx_tree_lookup_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 6;
  localparam int DIG_W  = 2;
  localparam int DEPTH  = 32;
  localparam int GID_W  = 6;
  localparam int FAN    = 1 << DIG_W;
  localparam int LEVELS = IDX_W / DIG_W;
  localparam int TAG    = (1 << GID_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              init_i;
  logic              key_valid_i;
  logic              key_ready_o;
  logic [DATA_W-1:0] key_i;
  logic              res_valid_o;
  logic [GID_W-1:0]  res_gid_o;
  logic              res_new_o;
  logic              res_ovf_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Behavioural reference state
  int grp_of[int];
  bit node_of[int];
  int used_slots;
  int n_groups;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gidx_tree_lookup #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .DIG_W(DIG_W), .DEPTH(DEPTH), .GID_W(GID_W)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .key_valid_i (key_valid_i),
    .key_ready_o (key_ready_o),
    .key_i       (key_i),
    .res_valid_o (res_valid_o),
    .res_gid_o   (res_gid_o),
    .res_new_o   (res_new_o),
    .res_ovf_o   (res_ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    grp_of.delete();
    node_of.delete();
    used_slots = FAN;
    n_groups   = 0;
  endtask

  // Expected outcome and latency of one key, from the requirements only
  task automatic model_key(input int idx, output int gid, output bit nw,
                           output bit ov, output int lat);
    int visited = 0;
    int blocks  = 0;
    ov = 1'b0; nw = 1'b0; gid = TAG;
    for (int j = 0; j < LEVELS; j++) begin
      visited++;
      if (j < LEVELS - 1) begin
        int pfx = ((j + 1) << 8) | (idx >> ((LEVELS - 1 - j) * DIG_W));
        if (!node_of.exists(pfx)) begin
          if (used_slots + FAN > DEPTH) begin
            ov = 1'b1;
            break;
          end
          node_of[pfx] = 1'b1;
          used_slots += FAN;
          blocks++;
        end
      end
    end
    if (!ov) begin
      if (grp_of.exists(idx)) begin
        gid = grp_of[idx];
      end else if (n_groups == TAG) begin
        ov = 1'b1;
      end else begin
        gid = n_groups;
        grp_of[idx] = n_groups;
        n_groups++;
        nw = 1'b1;
      end
    end
    lat = 2 * visited + FAN * blocks + 1;
  endtask

  task automatic send(input int idx, input int low, input string req);
    int eg, el;
    bit en, eo;
    model_key(idx, eg, en, eo, el);
    @(negedge clk);
    chk(key_ready_o == 1'b1, "R5", "ready before key", int'(key_ready_o), 1);
    key_valid_i = 1'b1;
    key_i = {idx[IDX_W-1:0], low[DATA_W-IDX_W-1:0]};
    for (int c = 1; c <= el; c++) begin
      @(negedge clk);
      key_valid_i = 1'b0;
      chk(key_ready_o == 1'b0, "R5", "ready while busy", int'(key_ready_o), 0);
      chk(res_valid_o == (c == el), "R4", "result strobe timing",
          int'(res_valid_o), int'(c == el));
      if (c == el) begin
        chk(int'(res_gid_o) == eg, req, "group number", int'(res_gid_o), eg);
        chk(res_new_o == en, req, "new flag", int'(res_new_o), int'(en));
        chk(res_ovf_o == eo, req, "overflow flag", int'(res_ovf_o), int'(eo));
      end
    end
  endtask

  task automatic do_init();
    @(negedge clk);
    chk(key_ready_o == 1'b1, "R9", "ready before init", int'(key_ready_o), 1);
    init_i      = 1'b1;
    key_valid_i = 1'b1;
    key_i       = 16'hFFFF;
    model_clear();
    for (int c = 1; c <= DEPTH; c++) begin
      @(negedge clk);
      init_i      = 1'b0;
      key_valid_i = 1'b0;
      chk(key_ready_o == 1'b0, "R9", "ready during clear", int'(key_ready_o), 0);
      chk(res_valid_o == 1'b0, "R9", "no result for key beside init",
          int'(res_valid_o), 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int wait_cyc;
    rst_n       = 1'b0;
    init_i      = 1'b0;
    key_valid_i = 1'b0;
    key_i       = '0;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk(key_ready_o == 1'b0, "R1", "ready in reset", int'(key_ready_o), 0);
    chk(res_valid_o == 1'b0, "R1", "result in reset", int'(res_valid_o), 0);
    rst_n = 1'b1;
    wait_cyc = 0;
    while (!key_ready_o && wait_cyc < DEPTH + 20) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk(wait_cyc >= DEPTH && wait_cyc <= DEPTH + 3, "R1", "clear cycles after reset",
        wait_cyc, DEPTH);

    send(6'b11_01_10, 10'h155, "R2");  // two blocks, group 0
    send(6'b11_01_10, 10'h2AA, "R3");  // same prefix, other low bits
    send(6'b11_01_11, 10'h000, "R6");  // last digit differs: nodes reused
    send(6'b11_00_00, 10'h3FF, "R2");  // one block
    send(6'b00_00_00, 10'h001, "R2");  // two blocks
    send(6'b01_00_01, 10'h123, "R2");  // two blocks, table now full
    send(6'b10_00_00, 10'h000, "R7");  // fails at the top level
    send(6'b00_01_00, 10'h000, "R7");  // fails at the middle level
    send(6'b00_00_11, 10'h0F0, "R8");  // leaf under existing nodes
    send(6'b11_01_10, 10'h00F, "R8");  // old group still found
    send(6'b01_00_01, 10'h3C3, "R3");

    do_init();
    send(6'b10_00_00, 10'h000, "R9");  // numbering restarts at 0
    send(6'b11_01_10, 10'h155, "R9");  // forgotten prefix is new again
    send(6'b10_00_00, 10'h111, "R3");
    send(6'b10_00_01, 10'h222, "R6");

    @(negedge clk);
    chk(key_ready_o == 1'b1, "R5", "ready after last result", int'(key_ready_o), 1);
    finish_run();
  end

endmodule